// File: doc/BRIEF.md
# Passive I2C Bus Observer

This block watches a two-wire I2C bus from the side and never drives it. SCL and SDA pass through a synchronizer into the system clock domain. The block then finds START and STOP conditions and assembles each 8-bit byte, most significant bit first, together with the acknowledge bit that follows it. It always acts as a receiving slave. It sends no acknowledge and never holds SCL low, even while a byte is waiting for the host.

Each completed byte is copied into a read buffer at the acknowledge clock, and an active-low pending flag drops. The first byte after a START is taken as the address byte, and its read/write bit and general-call status are latched. The host reads the buffer during the window that ends when the next byte completes. It watches the status outputs: the dual-purpose last-bit bit, the after-start flag, the stop-detected flag, bus-free and the error flag.

Top module: `i2c_bus_observer`

## Requirements
- R1: After reset, pend_n and bus_free are 1, while after_start, stop_det, err_det, gen_call, addr_rw and rx_byte are all 0.
- R2: SDA falling while SCL is high is a START. After a START that lands on a byte boundary, bus_free is 0, after_start is 1 and stop_det is 0.
- R3: SDA rising while SCL is high is a STOP. After a STOP, stop_det is 1 and bus_free is 1.
- R4: Bits are sampled on SCL rising edges, MSB first. On the ninth rising edge the eight data bits are copied to rx_byte and pend_n goes to 0. SDA changes while SCL is high are never taken as data.
- R5: pend_n goes back to 1 at the first SCL rising edge of the next byte. rx_byte keeps its value until the next ninth edge.
- R6: A one-cycle host_rd pulse while pend_n is 0 sets pend_n to 1.
- R7: While after_start is 0, last_bit_st shows the SDA level at the latest acknowledge clock (0 means acknowledged, 1 means not acknowledged).
- R8: after_start clears on the ninth SCL edge of the byte that follows the address byte. While after_start is 1, last_bit_st and gen_call are 1 exactly when the address byte was 00h.
- R9: addr_rw holds bit 0 (the LSB) of the latest address byte.
- R10: A START or STOP that arrives after two to eight bits of a byte is an error. err_det goes to 1, bus_free is forced to 1, pend_n is forced to 0 and the byte is dropped. err_det clears at the next START that lands on a byte boundary.
- R11: When no transfer is open, SCL pulses with SDA changing only while SCL is low leave pend_n, rx_byte and bus_free unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line, observed only |
| sda_i | input | 1 | Bus data line, observed only |
| host_rd | input | 1 | One-cycle strobe: host has read rx_byte |
| rx_byte | output | 8 | Read buffer holding the last complete byte |
| pend_n | output | 1 | Active-low byte-pending flag |
| last_bit_st | output | 1 | Last acknowledge bit, or the general-call indication while after_start is 1 |
| gen_call | output | 1 | Latest address byte was 00h |
| addr_rw | output | 1 | Read/write bit of the latest address byte |
| after_start | output | 1 | START seen, address phase not yet over |
| stop_det | output | 1 | A STOP has been seen since the last START |
| bus_free | output | 1 | Active-low busy: 0 while a transfer is open |
| err_det | output | 1 | Misplaced START or STOP detected |

## Verification
The bench targets the STOP that follows an acknowledge. There the SCL rise before the STOP looks like the first bit of a new byte, and a design that counted it would raise a false bus error. It also sends a STOP several bits into a byte, which a design without the error rule would accept as a normal end. A general-call address and a not-acknowledged byte test the dual meaning of last_bit_st, and a design that mixed up the two sources would report the wrong level. Finally, the bench checks that rx_byte holds its value after pend_n rises again, which catches a buffer that tracks the shift register live.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  // A condition is legal while at most one bit has been counted: that bit
  // belongs to the very SCL high period in which the condition happens.
  function automatic logic breaks_byte(input logic [CNT_W-1:0] cnt);
    return cnt >= CNT_W'(2);
  endfunction

  function automatic logic is_gen_call(input logic [BYTE_W-1:0] b);
    return b == '0;
  endfunction
endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] cur_o,
  output logic [LINES-1:0] prev_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], raw_i[g]};
    end
    assign cur_o[g]  = chain[STAGES-1];
    assign prev_o[g] = chain[STAGES];
  end
endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond (
  input  logic scl_s,
  input  logic scl_q,
  input  logic sda_s,
  input  logic sda_q,
  output logic start_ev,
  output logic stop_ev,
  output logic rise_ev
);
  logic scl_held_high;
  assign scl_held_high = scl_s & scl_q;
  assign start_ev = scl_held_high & sda_q & ~sda_s;
  assign stop_ev  = scl_held_high & ~sda_q & sda_s;
  assign rise_ev  = scl_s & ~scl_q;
endmodule

// File: rtl/i2cmon_frame.sv
module i2cmon_frame
  import i2cmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              rise_ev,
  output logic              start_ok,
  output logic              cond_err,
  output logic              byte_done,
  output logic              first_bit_ev,
  output logic              done_was_addr,
  output logic              ack_bit,
  output logic [BYTE_W-1:0] byte_val
);
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              in_frame;
  logic              addr_phase;
  logic              live_rise;

  assign live_rise     = rise_ev & in_frame;
  assign cond_err      = (start_ev | stop_ev) & in_frame & breaks_byte(bit_cnt);
  assign start_ok      = start_ev & ~cond_err;
  assign byte_done     = live_rise & (bit_cnt == CNT_W'(BYTE_W));
  assign first_bit_ev  = live_rise & (bit_cnt == '0);
  assign done_was_addr = addr_phase;
  assign ack_bit       = sda_s;
  assign byte_val      = shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      in_frame   <= 1'b0;
      addr_phase <= 1'b0;
    end else if (cond_err) begin
      bit_cnt  <= '0;
      in_frame <= 1'b0;
    end else if (start_ev) begin
      bit_cnt    <= '0;
      in_frame   <= 1'b1;
      addr_phase <= 1'b1;
    end else if (stop_ev) begin
      bit_cnt  <= '0;
      in_frame <= 1'b0;
    end else if (byte_done) begin
      bit_cnt    <= '0;
      addr_phase <= 1'b0;
    end else if (live_rise) begin
      shreg   <= {shreg[BYTE_W-2:0], sda_s};
      bit_cnt <= bit_cnt + CNT_W'(1);
    end
  end

  // R4: a byte completes only on an SCL rising edge inside an open frame
  assert_done_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (rise_ev && !start_ev && !stop_ev));
  // R10: a rejected condition closes the frame
  assert_err_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cond_err |=> !in_frame);
endmodule

// File: rtl/i2cmon_status.sv
module i2cmon_status
  import i2cmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              start_ok,
  input  logic              stop_ev,
  input  logic              cond_err,
  input  logic              byte_done,
  input  logic              first_bit_ev,
  input  logic              done_was_addr,
  input  logic              ack_bit,
  input  logic [BYTE_W-1:0] byte_val,
  output logic [BYTE_W-1:0] rx_buf,
  output logic              pend_n,
  output logic              last_bit_st,
  output logic              gen_call,
  output logic              addr_rw,
  output logic              after_start,
  output logic              stop_det,
  output logic              bus_free,
  output logic              err_det
);
  logic ack_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_buf      <= '0;
      ack_seen    <= 1'b0;
      gen_call    <= 1'b0;
      addr_rw     <= 1'b0;
      pend_n      <= 1'b1;
      after_start <= 1'b0;
      stop_det    <= 1'b0;
      bus_free    <= 1'b1;
      err_det     <= 1'b0;
    end else begin
      if (cond_err)                     pend_n <= 1'b0;
      else if (byte_done)               pend_n <= 1'b0;
      else if (first_bit_ev || host_rd) pend_n <= 1'b1;

      if (cond_err)      bus_free <= 1'b1;
      else if (start_ok) bus_free <= 1'b0;
      else if (stop_ev)  bus_free <= 1'b1;

      if (cond_err)      err_det <= 1'b1;
      else if (start_ok) err_det <= 1'b0;

      if (stop_ev)       stop_det <= 1'b1;
      else if (start_ok) stop_det <= 1'b0;

      if (start_ok)                         after_start <= 1'b1;
      else if (byte_done && !done_was_addr) after_start <= 1'b0;

      if (byte_done) begin
        rx_buf   <= byte_val;
        ack_seen <= ack_bit;
        if (done_was_addr) begin
          gen_call <= is_gen_call(byte_val);
          addr_rw  <= byte_val[0];
        end
      end
    end
  end

  assign last_bit_st = after_start ? gen_call : ack_seen;

  // R10: an error drops pend_n and releases bus_free in the same cycle
  assert_err_forces_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_det) |-> (!pend_n && bus_free));
  // R2: a boundary START opens the transfer
  assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (after_start && !bus_free && !stop_det));
  // R3: a STOP is always recorded
  assert_stop_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (stop_det && bus_free));
  // R5: the buffer moves only when a byte completes
  assert_buf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(rx_buf));
  // R4: a completed byte is announced
  assert_pend_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !pend_n);
endmodule

// File: rtl/i2c_bus_observer.sv
module i2c_bus_observer
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              host_rd,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              pend_n,
  output logic              last_bit_st,
  output logic              gen_call,
  output logic              addr_rw,
  output logic              after_start,
  output logic              stop_det,
  output logic              bus_free,
  output logic              err_det
);
  logic [1:0] line_cur, line_prev;
  logic start_ev, stop_ev, rise_ev;
  logic start_ok, cond_err, byte_done, first_bit_ev, done_was_addr, ack_bit;
  logic [BYTE_W-1:0] byte_val;

  i2cmon_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}),
    .cur_o(line_cur), .prev_o(line_prev));

  i2cmon_cond u_cond (
    .scl_s(line_cur[1]), .scl_q(line_prev[1]),
    .sda_s(line_cur[0]), .sda_q(line_prev[0]),
    .start_ev(start_ev), .stop_ev(stop_ev), .rise_ev(rise_ev));

  i2cmon_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sda_s(line_cur[0]),
    .start_ev(start_ev), .stop_ev(stop_ev), .rise_ev(rise_ev),
    .start_ok(start_ok), .cond_err(cond_err), .byte_done(byte_done),
    .first_bit_ev(first_bit_ev), .done_was_addr(done_was_addr),
    .ack_bit(ack_bit), .byte_val(byte_val));

  i2cmon_status u_status (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd),
    .start_ok(start_ok), .stop_ev(stop_ev), .cond_err(cond_err),
    .byte_done(byte_done), .first_bit_ev(first_bit_ev),
    .done_was_addr(done_was_addr), .ack_bit(ack_bit), .byte_val(byte_val),
    .rx_buf(rx_byte), .pend_n(pend_n), .last_bit_st(last_bit_st),
    .gen_call(gen_call), .addr_rw(addr_rw), .after_start(after_start),
    .stop_det(stop_det), .bus_free(bus_free), .err_det(err_det));
endmodule

// File: tb/tb_i2c_bus_observer.sv
module tb_i2c_bus_observer;
  localparam int T = 20;
  logic clk = 0, rst_n = 0, scl = 1, sda = 1, host_rd = 0;
  logic [7:0] rx_byte;
  logic pend_n, last_bit_st, gen_call, addr_rw, after_start, stop_det, bus_free, err_det;
  int checks = 0, errs = 0;
  logic [9:0] expq[$];   // {byte, last_bit_st, after_start}
  logic pend_prev = 1;

  always #5 clk = ~clk;

  i2c_bus_observer dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .host_rd(host_rd), .rx_byte(rx_byte), .pend_n(pend_n),
    .last_bit_st(last_bit_st), .gen_call(gen_call), .addr_rw(addr_rw),
    .after_start(after_start), .stop_det(stop_det), .bus_free(bus_free),
    .err_det(err_det));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start; sda = 0; hold(T); scl = 0; hold(T); endtask
  task automatic bus_bit(input logic b); sda = b; hold(T); scl = 1; hold(T); scl = 0; hold(T); endtask
  task automatic bus_stop; sda = 0; hold(T); scl = 1; hold(T); sda = 1; hold(T); endtask

  // driver: pushes the expected buffer item, then clocks the byte out
  task automatic send_byte(input logic [7:0] b, input logic ack, input logic exp_bit,
                           input logic exp_adr, input int from_bit);
    expq.push_back({b, exp_bit, exp_adr});
    for (int i = from_bit; i >= 0; i--) bus_bit(b[i]);
    bus_bit(ack);
  endtask

  // monitor: each clean fall of pend_n is compared with the queue head
  always @(negedge clk) begin
    if (rst_n && pend_prev && !pend_n && !err_det) begin
      if (expq.size() == 0) chk("R4 unexpected byte", 8'h01, 8'h00);
      else begin
        logic [9:0] e;
        e = expq.pop_front();
        chk("R4 rx_byte", rx_byte, e[9:2]);
        chk("R7/R8 last_bit_st", {7'd0, last_bit_st}, {7'd0, e[1]});
        chk("R8 after_start", {7'd0, after_start}, {7'd0, e[0]});
      end
    end
    pend_prev <= pend_n;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    hold(5); rst_n = 1; hold(3);
    // R1 reset state
    chk("R1 pend_n", {7'd0, pend_n}, 8'd1);
    chk("R1 bus_free", {7'd0, bus_free}, 8'd1);
    chk("R1 flags", {3'd0, after_start, stop_det, err_det, gen_call, addr_rw}, 8'd0);
    chk("R1 rx_byte", rx_byte, 8'd0);

    bus_start;
    chk("R2 bus_free", {7'd0, bus_free}, 8'd0);
    chk("R2 after_start", {7'd0, after_start}, 8'd1);
    chk("R2 stop_det", {7'd0, stop_det}, 8'd0);

    send_byte(8'hA5, 0, 0, 1, 7);
    chk("R9 addr_rw", {7'd0, addr_rw}, 8'd1);
    chk("R8 gen_call", {7'd0, gen_call}, 8'd0);
    chk("R4 pend_n low", {7'd0, pend_n}, 8'd0);
    bus_bit(0);                           // first bit of 3Ch
    chk("R5 pend_n back", {7'd0, pend_n}, 8'd1);
    chk("R5 rx_byte held", rx_byte, 8'hA5);
    send_byte(8'h3C, 0, 0, 0, 6);
    send_byte(8'hFF, 1, 1, 0, 7);         // R7 not acknowledged
    chk("R6 pend_n before read", {7'd0, pend_n}, 8'd0);
    host_rd = 1; hold(1); host_rd = 0; hold(2);
    chk("R6 pend_n after read", {7'd0, pend_n}, 8'd1);
    bus_stop;
    chk("R3 stop_det", {7'd0, stop_det}, 8'd1);
    chk("R3 bus_free", {7'd0, bus_free}, 8'd1);
    chk("R3 no error", {7'd0, err_det}, 8'd0);

    bus_start;
    send_byte(8'h00, 0, 1, 1, 7);         // R8 general call
    chk("R8 gen_call", {7'd0, gen_call}, 8'd1);
    chk("R9 addr_rw", {7'd0, addr_rw}, 8'd0);
    send_byte(8'h81, 0, 0, 0, 7);

    // R10: STOP after four bits of a byte
    bus_bit(1); bus_bit(0); bus_bit(1);
    bus_stop;
    chk("R10 err_det", {7'd0, err_det}, 8'd1);
    chk("R10 bus_free", {7'd0, bus_free}, 8'd1);
    chk("R10 pend_n", {7'd0, pend_n}, 8'd0);
    chk("R10 rx_byte kept", rx_byte, 8'h81);

    bus_start;
    chk("R10 err cleared", {7'd0, err_det}, 8'd0);
    send_byte(8'h5A, 0, 0, 1, 7);
    chk("R9 addr_rw", {7'd0, addr_rw}, 8'd0);
    bus_stop;

    // R11: idle SCL pulses outside a transfer
    host_rd = 1; hold(1); host_rd = 0; hold(2);
    scl = 0; hold(T); sda = 0; hold(T); scl = 1; hold(T); scl = 0; hold(T);
    sda = 1; hold(T); scl = 1; hold(T);
    chk("R11 pend_n", {7'd0, pend_n}, 8'd1);
    chk("R11 rx_byte", rx_byte, 8'h5A);
    chk("R11 bus_free", {7'd0, bus_free}, 8'd1);
    chk("R4 queue drained", 8'(expq.size()), 8'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule